// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the bit clock for a serial shift engine. It divides one of two sources: the internal system clock, or an external clock pin. An 8-bit divide value sets the length of the high and low phases. The external clock is brought into the system domain by a two-flop synchronizer. Each rising edge found there counts as one input period.

Alongside the clock, the block gives two single-cycle strobes, both in the system clock domain. The lead strobe marks the start of the clock's active phase. The trail strobe marks its end. A shift engine that runs on the system clock can launch and capture data on these strobes. A polarity input inverts the output pin. The strobes stay tied to the active phase, so with polarity set the lead strobe falls on the pin's falling edge.

A new divide value is picked up only at the start of an active phase. Deasserting enable parks the clock at its inactive level.

Top module: `bclk_gen`

## Requirements
- R1: While rst_ni is low, bclk_o equals pol_i, and both strobes are 0.
- R2: With src_sys_i = 1 and an odd divide value N, the active phase lasts (N+1)/2 system cycles and the inactive phase lasts (N+1)/2 system cycles.
- R3: With src_sys_i = 1 and an even, nonzero divide value N, the active phase lasts N/2+1 system cycles and the inactive phase lasts N/2 system cycles.
- R4: A divide value of 0 gives a one-cycle active phase followed by a one-cycle inactive phase.
- R5: With src_sys_i = 0, each phase is counted in rising edges of ext_clk_i after a two-flop synchronizer. With N = 3 and an external period of 4 system cycles, each phase lasts 8 system cycles.
- R6: The active level of bclk_o is the inverse of pol_i. With pol_i = 1, the output is low while active, and lead_stb_o coincides with the pin's falling edge.
- R7: lead_stb_o is high for exactly the first system cycle of each active phase. trail_stb_o is high for exactly the first cycle after an active phase ends. The two strobes are never high together.
- R8: A divide value changed during a period is used from the next lead strobe onward. The period in progress completes with the old value.
- R9: Enable low, sampled at a clock edge, puts bclk_o at its inactive level (equal to pol_i) from that edge on. Enable high, sampled while idle, starts a full active phase at that edge, with lead_stb_o high.
- R10: The clock period is never shorter than two system cycles. No two lead strobes occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External source clock, asynchronous |
| src_sys_i | input | 1 | 1: count system cycles, 0: count external rising edges |
| div_i | input | 8 | Divide value N |
| pol_i | input | 1 | 1 inverts the output clock |
| en_i | input | 1 | Run enable |
| bclk_o | output | 1 | Generated bit clock |
| lead_stb_o | output | 1 | One-cycle strobe at the start of the active phase |
| trail_stb_o | output | 1 | One-cycle strobe at the end of the active phase |

## Verification
The assertions assume pol_i changes only while the generator is disabled, because the output level is compared with pol_i one cycle after enable is seen low. They also assume each level of ext_clk_i lasts at least two system cycles, so the synchronizer sees every edge. The stimulus meets both assumptions. Polarity is set only while the generator is held idle or at a lead strobe with a fresh measurement afterwards. The external clock toggles every two system cycles, away from the sampling edge.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  typedef enum logic {
    SRC_EXT = 1'b0,
    SRC_SYS = 1'b1
  } src_sel_e;

  localparam int unsigned BCLK_DIV_W = 8;
  localparam int unsigned BCLK_SYNC_STAGES = 2;
endpackage

// File: rtl/bclk_src.sv
module bclk_src #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic src_sys_i,
  output logic tick_o
);
  import bclk_pkg::*;

  // sync chain plus one history bit for edge detection
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign tick_o   = (src_sel_e'(src_sys_i) == SRC_SYS) ? 1'b1 : ext_rise;
endmodule

// File: rtl/bclk_div.sv
module bclk_div #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             act_o,
  output logic             lead_o,
  output logic             trail_o
);
  logic             run_q, run_d, hi_q, hi_d, lead_q, lead_d, trail_q, trail_d;
  logic [DIV_W-1:0] cnt_q, cnt_d, div_q, div_d, cur_len;

  function automatic logic [DIV_W-1:0] hi_len(input logic [DIV_W-1:0] n);
    return (n >> 1) + DIV_W'(1);
  endfunction

  function automatic logic [DIV_W-1:0] lo_len(input logic [DIV_W-1:0] n);
    if (n == '0)  return DIV_W'(1);  // keeps period at two cycles minimum
    else if (n[0]) return (n >> 1) + DIV_W'(1);
    else           return n >> 1;
  endfunction

  assign cur_len = hi_q ? hi_len(div_q) : lo_len(div_q);

  always_comb begin
    run_d   = run_q;
    hi_d    = hi_q;
    cnt_d   = cnt_q;
    div_d   = div_q;
    lead_d  = 1'b0;
    trail_d = 1'b0;
    if (!en_i) begin
      run_d   = 1'b0;
      hi_d    = 1'b0;
      cnt_d   = '0;
      trail_d = hi_q;
    end else if (!run_q) begin
      run_d  = 1'b1;
      hi_d   = 1'b1;
      cnt_d  = '0;
      div_d  = div_i;
      lead_d = 1'b1;
    end else if (tick_i) begin
      if (cnt_q == cur_len - DIV_W'(1)) begin
        cnt_d   = '0;
        hi_d    = ~hi_q;
        lead_d  = ~hi_q;
        trail_d = hi_q;
        if (!hi_q) div_d = div_i;  // new value only at start of active phase
      end else begin
        cnt_d = cnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      hi_q    <= 1'b0;
      cnt_q   <= '0;
      div_q   <= '0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      run_q   <= run_d;
      hi_q    <= hi_d;
      cnt_q   <= cnt_d;
      div_q   <= div_d;
      lead_q  <= lead_d;
      trail_q <= trail_d;
    end
  end

  assign act_o   = hi_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  AST_DIV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && !lead_q) |-> $stable(div_q)); // R8
  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (cnt_q < cur_len)); // R2
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen #(
  parameter int unsigned DIV_W       = bclk_pkg::BCLK_DIV_W,
  parameter int unsigned SYNC_STAGES = bclk_pkg::BCLK_SYNC_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             src_sys_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             pol_i,
  input  logic             en_i,
  output logic             bclk_o,
  output logic             lead_stb_o,
  output logic             trail_stb_o
);
  logic tick, act;

  bclk_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_clk_i(ext_clk_i),
    .src_sys_i(src_sys_i),
    .tick_o   (tick)
  );

  bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick),
    .div_i  (div_i),
    .act_o  (act),
    .lead_o (lead_stb_o),
    .trail_o(trail_stb_o)
  );

  assign bclk_o = act ^ pol_i;

  AST_LEAD_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_stb_o |-> (bclk_o != pol_i)); // R6
  AST_TRAIL_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_stb_o |-> (bclk_o == pol_i)); // R7
  AST_STB_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({lead_stb_o, trail_stb_o})); // R7
  AST_MIN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_stb_o |=> !lead_stb_o); // R10
  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (bclk_o == pol_i)); // R9
endmodule

// File: tb/bclk_gen_tb_top.sv
module bclk_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       src_sys_i = 1'b1;
  logic [7:0] div_i = 8'd1;
  logic       pol_i = 1'b0;
  logic       en_i = 1'b0;
  logic       bclk_o, lead_stb_o, trail_stb_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int r10_bad = 0;
  logic prev_lead = 1'b0;

  bclk_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .src_sys_i(src_sys_i),
    .div_i(div_i), .pol_i(pol_i), .en_i(en_i),
    .bclk_o(bclk_o), .lead_stb_o(lead_stb_o), .trail_stb_o(trail_stb_o)
  );

  always #2 clk_i = ~clk_i;  // 250 MHz
  initial begin #1; forever #8 ext_clk_i = ~ext_clk_i; end  // 4-cycle period

  // {div, expected active cycles, expected inactive cycles}
  localparam int NV = 6;
  localparam int VEC [NV][3] = '{
    '{1, 1, 1}, '{2, 2, 1}, '{3, 2, 2}, '{6, 4, 3}, '{9, 5, 5}, '{0, 1, 1}
  };

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (rst_ni && lead_stb_o && prev_lead) r10_bad++;
    prev_lead = lead_stb_o;
    if (cyc > 100000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at a negedge; returns at the negedge of the next lead strobe
  task automatic measure(output int hi_n, output int lo_n);
    int g = 0;
    while (!lead_stb_o && g < 2000) begin @(negedge clk_i); g++; end
    hi_n = 0;
    while (bclk_o != pol_i && g < 4000) begin hi_n++; @(negedge clk_i); g++; end
    lo_n = 0;
    while (bclk_o == pol_i && g < 6000) begin lo_n++; @(negedge clk_i); g++; end
  endtask

  initial begin
    int h, l;
    repeat (3) @(negedge clk_i);
    chk("R1 reset level", int'(bclk_o), 0);
    chk("R1 reset strobes", int'({lead_stb_o, trail_stb_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    en_i = 1'b1;
    for (int i = 0; i < NV; i++) begin
      div_i = 8'(VEC[i][0]);
      measure(h, l);
      measure(h, l);
      chk((VEC[i][0] == 0) ? "R4 active" : (VEC[i][0] % 2 == 1) ? "R2 active" : "R3 active",
          h, VEC[i][1]);
      chk((VEC[i][0] == 0) ? "R4 inactive" : (VEC[i][0] % 2 == 1) ? "R2 inactive" : "R3 inactive",
          l, VEC[i][2]);
    end

    // R8: change during a running period
    div_i = 8'd5;
    measure(h, l);
    measure(h, l);
    div_i = 8'd2;
    measure(h, l);
    chk("R8 old active", h, 3);
    chk("R8 old inactive", l, 3);
    measure(h, l);
    chk("R8 new active", h, 2);
    chk("R8 new inactive", l, 1);

    // R9: disable and re-enable
    en_i = 1'b0;
    @(negedge clk_i);
    chk("R9 idle level", int'(bclk_o), int'(pol_i));
    repeat (5) @(negedge clk_i);
    chk("R9 idle held", int'({bclk_o, lead_stb_o}), 0);
    div_i = 8'd6;
    pol_i = 1'b1;
    @(negedge clk_i);
    chk("R6 idle level inverted", int'(bclk_o), 1);
    en_i = 1'b1;
    @(negedge clk_i);
    chk("R9 restart lead", int'(lead_stb_o), 1);
    chk("R6 active low at lead", int'(bclk_o), 0);
    measure(h, l);
    chk("R9 full first active", h, 4);
    measure(h, l);
    chk("R6 inverted inactive", l, 3);

    // R5: external source
    en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    pol_i = 1'b0;
    src_sys_i = 1'b0;
    div_i = 8'd3;
    en_i = 1'b1;
    measure(h, l);
    measure(h, l);
    chk("R5 ext active", h, 8);
    chk("R5 ext inactive", l, 8);

    // R7: trail strobe one cycle after active phase
    src_sys_i = 1'b1;
    div_i = 8'd4;
    measure(h, l);
    measure(h, l);
    repeat (3) @(negedge clk_i);
    chk("R7 trail strobe", int'({trail_stb_o, lead_stb_o, bclk_o}), 4);
    @(negedge clk_i);
    chk("R7 trail single", int'(trail_stb_o), 0);

    chk("R10 back-to-back leads", r10_bad, 0);
    finish_run();
  end
endmodule